// File: doc/BRIEF.md
# Dual-Source Interrupt Counter

This block raises a level interrupt toward the CPU from one of two counting sources, picked through a small group of four write-only registers. In cycle mode a 16-bit down-counter steps once per CPU bus cycle, marked by `m2_en_i`. It raises the interrupt when it arrives at zero and then stays at zero. In line mode an 8-bit counter steps on qualified rising edges of the video address line A12. It reloads from a latch when it is empty or when a reload has been requested, so it can count a programmable number of rendered lines.

The same four registers serve both modes. The low and high count registers load the 16-bit counter in cycle mode. In line mode they act as reload-request and latch writes. A mode register selects the source, holds the enable, and can turn on an automatic scheme in which the count writes also disable and re-enable the interrupt. Only writes that fall in the block's own address group are taken. Decoding of any other register is left to the surrounding logic.

Top module: `dual_irq_counter`

## Requirements
- R1: Asynchronous reset (`rst_ni` low) drives `irq_o` low and clears both counters, the latch, the reload request, the enable, the automatic flag and the source, which selects cycle mode. With both counters at zero, enabling cycle mode and giving one `m2_en_i` pulse raises the interrupt.
- R2: A write is taken when `wr_en_i` is high and `addr_i[15:12]` is 0xC. Bits 11:2 are ignored, and `addr_i[1:0]` selects one of four registers: 0 count-low, 1 count-high, 2 mode, 3 gate. In the mode register, bit 0 is the enable, bit 1 is the source (0 cycle, 1 line) and bit 2 is the automatic flag. Writes outside the group have no effect.
- R3: In cycle mode, a count-low write replaces bits 7:0 of the 16-bit counter and a count-high write replaces bits 15:8. A load made in the same cycle as an `m2_en_i` pulse takes priority, and that pulse is not counted.
- R4: In cycle mode, each `m2_en_i` pulse while enabled decrements the counter. While disabled the counter holds.
- R5: In cycle mode, a pulse that finds the counter at 1 or 0 while enabled raises the interrupt. The counter stays at zero and never wraps.
- R6: In line mode, a count-low write sets the reload request and a count-high write loads the 8-bit latch.
- R7: In line mode, each qualified A12 rise reloads the counter from the latch if the counter is zero or a reload is requested, and clears the request. Otherwise it decrements the counter. The interrupt is raised if the result is zero and the enable is set. Counting goes on while the enable is clear.
- R8: An A12 rise is qualified only if A12 was sampled low on at least 3 `m2_en_i` pulses since it last went low.
- R9: With the automatic flag set, a count-low write clears the enable, a count-high write sets it, and gate writes are ignored. With the flag clear, count writes leave the enable alone, and gate bit 0 writes the enable.
- R10: Any write that leaves the enable clear also drops `irq_o`. Otherwise a raised interrupt stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m2_en_i | input | 1 | One-cycle pulse per CPU bus cycle |
| wr_en_i | input | 1 | CPU write strobe, one cycle |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data |
| a12_i | input | 1 | Video address line A12 |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Register writes, `m2_en_i` pulses and A12 edges all act on the clock edge at which they are sampled, so `irq_o` settles one edge after the stimulus that causes it. Inputs are driven just after a falling edge, and every result is read at the next falling edge. A behavioural model steps in the bench on each rising edge and is compared with `irq_o` on every falling edge. Directed checks after each burst of pulses or A12 edges confirm the exact pulse on which the interrupt arrives, for example the 256th pulse after a high-byte load, or the third qualified edge after a reload request.

// File: rtl/irq_ctr_pkg.sv
package irq_ctr_pkg;
  localparam int unsigned NREG  = 4;
  localparam int unsigned SEL_W = $clog2(NREG);

  localparam int unsigned MODE_EN_BIT   = 0;
  localparam int unsigned MODE_SRC_BIT  = 1;
  localparam int unsigned MODE_AUTO_BIT = 2;

  typedef enum logic [SEL_W-1:0] {
    REG_CNT_LO = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_MODE   = 2'd2,
    REG_GATE   = 2'd3
  } reg_sel_e;

  typedef enum logic {
    SRC_CPU  = 1'b0,
    SRC_LINE = 1'b1
  } src_e;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic mode;
    logic gate;
  } wr_stb_t;
endpackage

// File: rtl/irq_ctr_decode.sv
module irq_ctr_decode
  import irq_ctr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [3:0]  REG_BASE = 4'hC
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_stb_t           stb_o
);
  logic            grp_hit;
  logic [NREG-1:0] hit;
  logic            addr_unused;

  assign grp_hit     = wr_i && (addr_i[ADDR_W-1 -: 4] == REG_BASE);
  assign addr_unused = ^addr_i[ADDR_W-5:SEL_W];

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign hit[g] = grp_hit && (addr_i[SEL_W-1:0] == SEL_W'(g));
  end

  assign stb_o.cnt_lo = hit[REG_CNT_LO];
  assign stb_o.cnt_hi = hit[REG_CNT_HI];
  assign stb_o.mode   = hit[REG_MODE];
  assign stb_o.gate   = hit[REG_GATE];
endmodule

// File: rtl/irq_ctr_ctrl.sv
module irq_ctr_ctrl
  import irq_ctr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_stb_t           stb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fire_cpu_i,
  input  logic              fire_line_i,
  output logic              en_o,
  output src_e              src_o,
  output logic              irq_o
);
  logic en_q, en_d, auto_q, irq_q, irq_d, fire;
  src_e src_q;

  always_comb begin
    en_d = en_q;
    if (stb_i.mode)                 en_d = data_i[MODE_EN_BIT];
    else if (stb_i.gate && !auto_q) en_d = data_i[MODE_EN_BIT];
    else if (stb_i.cnt_lo && auto_q) en_d = 1'b0;
    else if (stb_i.cnt_hi && auto_q) en_d = 1'b1;
  end

  // cycle counter gates its own fire with enable; line fire is gated here
  assign fire  = (src_q == SRC_CPU) ? fire_cpu_i : (fire_line_i && en_q);
  assign irq_d = en_d ? (irq_q || fire) : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      src_q  <= SRC_CPU;
      irq_q  <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
      if (stb_i.mode) begin
        auto_q <= data_i[MODE_AUTO_BIT];
        src_q  <= src_e'(data_i[MODE_SRC_BIT]);
      end
    end
  end

  assign en_o  = en_q;
  assign src_o = src_q;
  assign irq_o = irq_q;

  a_r9_auto_lo_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i.cnt_lo && auto_q) |=> !en_q);
  a_r9_auto_gate_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i.gate && auto_q) |=> (en_q == $past(en_q)));
  a_r10_drop_with_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> !irq_q);
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !stb_i.mode && !stb_i.gate && !stb_i.cnt_lo) |=> irq_q);
endmodule

// File: rtl/irq_ctr_cpu.sv
module irq_ctr_cpu #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              fire_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ld_lo, ld_hi;

  assign ld_lo = active_i && ld_lo_i;
  assign ld_hi = active_i && ld_hi_i;

  always_comb begin
    cnt_d  = cnt_q;
    fire_o = 1'b0;
    if (ld_lo) begin
      cnt_d = {cnt_q[CNT_W-1:DATA_W], data_i};
    end else if (ld_hi) begin
      cnt_d = {data_i[HI_W-1:0], cnt_q[DATA_W-1:0]};
    end else if (active_i && en_i && tick_i) begin
      fire_o = (cnt_q <= CNT_W'(1));
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  a_r5_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !ld_lo && !ld_hi) |=> (cnt_q == '0));
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && en_i && tick_i && !ld_lo && !ld_hi && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ld_lo && !ld_hi) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/irq_ctr_a12_filter.sv
module irq_ctr_a12_filter #(
  parameter int unsigned FILT_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a12_i,
  input  logic m2_en_i,
  output logic rise_o
);
  localparam int unsigned LW = $clog2(FILT_CYC + 1);

  logic [LW-1:0] low_cnt_q;
  logic          a12_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      a12_q     <= 1'b0;
    end else begin
      a12_q <= a12_i;
      if (a12_i)
        low_cnt_q <= '0;
      else if (m2_en_i && low_cnt_q < LW'(FILT_CYC))
        low_cnt_q <= low_cnt_q + LW'(1);
    end
  end

  assign rise_o = a12_i && !a12_q && (low_cnt_q >= LW'(FILT_CYC));

  a_r8_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> $past(!a12_i));
endmodule

// File: rtl/irq_ctr_line.sv
module irq_ctr_line #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              tick_i,
  input  logic              set_reload_i,
  input  logic              ld_latch_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              fire_o
);
  logic [LINE_W-1:0] cnt_q, cnt_d, latch_q;
  logic              rflag_q, tick, set_rf, ld_latch;

  assign tick     = active_i && tick_i;
  assign set_rf   = active_i && set_reload_i;
  assign ld_latch = active_i && ld_latch_i;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q == '0 || rflag_q) cnt_d = latch_q;
      else                        cnt_d = cnt_q - LINE_W'(1);
    end
  end

  assign fire_o = tick && (cnt_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      latch_q <= '0;
      rflag_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ld_latch)  latch_q <= data_i[LINE_W-1:0];
      if (set_rf)    rflag_q <= 1'b1;
      else if (tick) rflag_q <= 1'b0;
    end
  end

  a_r6_request_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_rf |=> rflag_q);
  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (cnt_q == '0 || rflag_q)) |=> (cnt_q == $past(latch_q)));
endmodule

// File: rtl/dual_irq_counter.sv
module dual_irq_counter
  import irq_ctr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned LINE_W   = 8,
  parameter int unsigned FILT_CYC = 3,
  parameter logic [3:0]  REG_BASE = 4'hC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m2_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              a12_i,
  output logic              irq_o
);
  wr_stb_t stb;
  logic    en, fire_cpu, fire_line, a12_rise;
  src_e    src;

  irq_ctr_decode #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) u_decode (
    .wr_i(wr_en_i), .addr_i(addr_i), .stb_o(stb)
  );

  irq_ctr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .stb_i(stb), .data_i,
    .fire_cpu_i(fire_cpu), .fire_line_i(fire_line),
    .en_o(en), .src_o(src), .irq_o
  );

  irq_ctr_cpu #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cpu (
    .clk_i, .rst_ni, .active_i(src == SRC_CPU), .en_i(en), .tick_i(m2_en_i),
    .ld_lo_i(stb.cnt_lo), .ld_hi_i(stb.cnt_hi), .data_i, .fire_o(fire_cpu)
  );

  irq_ctr_a12_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk_i, .rst_ni, .a12_i, .m2_en_i, .rise_o(a12_rise)
  );

  irq_ctr_line #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_line (
    .clk_i, .rst_ni, .active_i(src == SRC_LINE), .tick_i(a12_rise),
    .set_reload_i(stb.cnt_lo), .ld_latch_i(stb.cnt_hi), .data_i,
    .fire_o(fire_line)
  );

  a_r5_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fire_cpu || fire_line));
endmodule

// File: tb/dual_irq_counter_bench.sv
module dual_irq_counter_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        m2_en = 1'b0, wr_en = 1'b0, a12 = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  int m_cnt, m_lc, m_latch, m_low;
  bit m_rf, m_en, m_line, m_auto, m_irq, m_a12p;

  always #4 clk = ~clk;

  dual_irq_counter u_dual_irq_counter (
    .clk_i(clk), .rst_ni(rst_n), .m2_en_i(m2_en), .wr_en_i(wr_en),
    .addr_i(addr), .data_i(data), .a12_i(a12), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_lc = 0; m_latch = 0; m_low = 0;
      m_rf = 0; m_en = 0; m_line = 0; m_auto = 0; m_irq = 0; m_a12p = 0;
    end else begin
      bit hit, fire, rise, new_en;
      int sel;
      hit  = wr_en && (addr[15:12] == 4'hC);
      sel  = int'(addr[1:0]);
      rise = a12 && !m_a12p && (m_low >= 3);
      fire = 0;
      if (!m_line) begin
        if (hit && sel == 0)      m_cnt = (m_cnt & 32'hFF00) | int'(data);
        else if (hit && sel == 1) m_cnt = (m_cnt & 32'h00FF) | (int'(data) << 8);
        else if (m_en && m2_en) begin
          fire = (m_cnt <= 1);
          if (m_cnt > 0) m_cnt = m_cnt - 1;
        end
      end else begin
        if (rise) begin
          if (m_lc == 0 || m_rf) m_lc = m_latch; else m_lc = m_lc - 1;
          fire = m_en && (m_lc == 0);
          m_rf = 0;
        end
        if (hit && sel == 0) m_rf = 1;
        if (hit && sel == 1) m_latch = int'(data);
      end
      new_en = m_en;
      if (hit && sel == 2)                new_en = data[0];
      else if (hit && sel == 3 && !m_auto) new_en = data[0];
      else if (hit && sel == 0 && m_auto)  new_en = 0;
      else if (hit && sel == 1 && m_auto)  new_en = 1;
      if (hit && sel == 2) begin m_line = data[1]; m_auto = data[2]; end
      m_irq = new_en ? (m_irq | fire) : 1'b0;
      m_en  = new_en;
      if (a12) m_low = 0; else if (m2_en && m_low < 3) m_low = m_low + 1;
      m_a12p = a12;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL %s model compare: irq_o=%0b expected %0b at cycle %0d", tag, irq, m_irq, cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", cycles, 100000);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic expect_irq(input bit exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s directed: irq_o=%0b expected %0b", req, irq, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; data = d; m2_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      m2_en = 1'b1;
      @(negedge clk);
    end
    m2_en = 1'b0;
  endtask

  task automatic a12_pulse(input int low_pulses);
    a12 = 1'b0;
    ticks(low_pulses);
    a12 = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; expect_irq(0, "R1");
    wr(16'hC002, 8'h01); ticks(1);
    expect_irq(1, "R1");

    tag = "R3";
    wr(16'hC003, 8'h00); expect_irq(0, "R10");
    wr(16'hC000, 8'h05); wr(16'hC001, 8'h00); wr(16'hC003, 8'h01);
    ticks(4); expect_irq(0, "R4");
    ticks(1); expect_irq(1, "R3");

    tag = "R5";
    ticks(3); expect_irq(1, "R10");
    wr(16'hC003, 8'h00); wr(16'hC003, 8'h01);
    ticks(1); expect_irq(1, "R5");
    wr(16'hC000, 8'h00); expect_irq(1, "R9");

    tag = "R4";
    wr(16'hC003, 8'h00);
    wr(16'hC000, 8'h00); wr(16'hC001, 8'h01);
    ticks(20); expect_irq(0, "R4");
    wr(16'hC003, 8'h01);
    ticks(255); expect_irq(0, "R4");
    ticks(1); expect_irq(1, "R3");

    tag = "R2";
    wr(16'hC7F7, 8'h00); expect_irq(0, "R2");
    wr(16'hD003, 8'h01); wr(16'h8003, 8'h01);
    wr(16'hC000, 8'h01);
    ticks(2); expect_irq(0, "R2");
    wr(16'hCFFE, 8'h01);
    ticks(1); expect_irq(1, "R2");

    tag = "R9";
    wr(16'hC002, 8'h04); expect_irq(0, "R10");
    wr(16'hC000, 8'h02); wr(16'hC001, 8'h00);
    ticks(1); expect_irq(0, "R9");
    ticks(1); expect_irq(1, "R9");
    wr(16'hC003, 8'h00); expect_irq(1, "R9");
    wr(16'hC000, 8'h05); expect_irq(0, "R9");

    tag = "R6";
    wr(16'hC002, 8'h03);
    wr(16'hC001, 8'h02); wr(16'hC000, 8'h00);
    a12_pulse(4); expect_irq(0, "R6");
    a12_pulse(4); expect_irq(0, "R7");
    a12_pulse(4); expect_irq(1, "R7");

    tag = "R8";
    wr(16'hC002, 8'h02); expect_irq(0, "R10");
    a12_pulse(4); a12_pulse(4);
    wr(16'hC002, 8'h03);
    a12_pulse(2); expect_irq(0, "R8");
    a12_pulse(3); expect_irq(1, "R7");
    tag = "R8";
    a12_pulse(1); expect_irq(1, "R8");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule